// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block mirrors the row state of every bank on one DDR3-style memory channel. The channel has 4 ranks with 8 independent banks each, which gives 32 tracked banks indexed by the concatenation {rank, bank}. Each bank holds at most one open row, and that row index is 16 bits wide. The tracker observes the command stream the controller issues: activate, precharge, precharge-all, read and write. From that stream it keeps an open/idle flag and a stored row for every bank.

A scheduler presents a candidate request on a separate lookup port. The tracker answers combinationally with one of three classes. HIT means the wanted row is already open. EMPTY means the bank is idle and needs an activate. CONFLICT means another row is open, so the bank needs a precharge and then an activate. The scheduler can then favour requests that avoid a new activation.

The tracker also checks each command against the current bank state. When a command is illegal for that state, it raises a one-cycle error pulse and leaves all state unchanged.

Each bank is a two-state machine with states BS_IDLE and BS_OPEN. Transition T_OPEN (BS_IDLE to BS_OPEN) fires on a legal activate. Transition T_CLOSE (BS_OPEN to BS_IDLE) fires on a precharge or precharge-all that covers the bank. The error reporter is a second two-state machine with states EP_QUIET and EP_FLAG. Transition T_RAISE enters EP_FLAG on an illegal command. Transition T_DROP returns to EP_QUIET on any cycle without one.

Top module: `bank_row_tracker`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) marks all 32 banks idle and clears proto_err. After reset, every lookup reports EMPTY.
- R2: The cmd_op encoding is 0 no-op, 1 activate, 2 precharge, 3 precharge-all, 4 read, 5 write; codes 6 and 7 are reserved. An activate with cmd_valid high to an idle bank opens that bank at the next edge and stores cmd_row. From then on, a lookup of that bank with the same row reports HIT.
- R3: The req_class encoding is 2'b00 EMPTY (bank idle), 2'b01 HIT (bank open and the stored row equals req_row) and 2'b10 CONFLICT (bank open with a different row). The code 2'b11 never appears.
- R4: A command changes only the bank or banks it addresses. Banks in the same rank with another bank number, and banks of other ranks, keep their state.
- R5: A precharge makes the addressed bank idle. A precharge to a bank that is already idle is legal and raises no error.
- R6: A precharge-all makes all 8 banks of the addressed rank idle and raises no error. It leaves every other rank untouched.
- R7: An activate to a bank that is already open is illegal. It leaves all state unchanged, and proto_err is high for exactly the cycle after the edge that sampled the command.
- R8: A read or write to an idle bank, or to an open bank whose stored row differs from cmd_row, is illegal. It leaves the state unchanged and pulses proto_err as in R7. A read or write to the matching open row is legal, changes nothing and raises no error.
- R9: req_class depends combinationally on the lookup inputs and the stored state. When the lookup and a command address the same bank in the same cycle, the lookup reports the state before that command's update.
- R10: With cmd_valid low, or with a no-op or reserved opcode, no state changes and proto_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Qualifies the command inputs |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_rank | input | 2 | Rank addressed by the command |
| cmd_bank | input | 3 | Bank within the rank addressed by the command |
| cmd_row | input | 16 | Row for activate, read and write |
| req_rank | input | 2 | Rank of the request being classified |
| req_bank | input | 3 | Bank of the request being classified |
| req_row | input | 16 | Row the request needs |
| req_class | output | 2 | Lookup result: EMPTY, HIT or CONFLICT (see R3) |
| proto_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
The classifier is exercised with three patterns:
- A request for the row just opened, which must give HIT.
- A request for a different row of the same open bank, which separates CONFLICT from HIT.
- A request to a freshly precharged or never-opened bank, which separates EMPTY from both.

The tests pair banks that share a rank but differ in bank number with banks that share a bank number across ranks. Those pairs show whether a precharge or precharge-all leaks into a neighbour. Illegal commands are interleaved with legal ones, and the bank is looked up afterwards. That order shows whether an illegal command wrongly changes state, in addition to whether it flags. A lookup that shares its cycle with an activate tells a pre-update answer from a post-update one.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_PRE  = 3'd2,
        OP_PREA = 3'd3,
        OP_RD   = 3'd4,
        OP_WR   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_EMPTY    = 2'b00,
        CLS_HIT      = 2'b01,
        CLS_CONFLICT = 2'b10
    } row_cls_e;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_OPEN = 1'b1
    } bank_st_e;

    typedef enum logic {
        EP_QUIET = 1'b0,
        EP_FLAG  = 1'b1
    } err_st_e;

endpackage

// File: rtl/bank_row_slot.sv
module bank_row_slot
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row
);

    bank_st_e   st_q;
    bank_st_e   st_d;
    logic [ROW_W-1:0] row_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= BS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // row register: captured only on T_OPEN
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (st_q == BS_IDLE && open_req) begin
            row_q <= row_in;
        end
    end

    // next-state: T_OPEN and T_CLOSE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_IDLE: if (open_req)  st_d = BS_OPEN;
            BS_OPEN: if (close_req) st_d = BS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_open  = (st_q == BS_OPEN);
        open_row = row_q;
    end

endmodule

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_trk_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    localparam int SLOT_W    = RANK_W + BANK_W,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_op,
    input  logic [RANK_W-1:0]                 cmd_rank,
    input  logic [BANK_W-1:0]                 cmd_bank,
    input  logic [ROW_W-1:0]                  cmd_row,
    input  logic [NUM_SLOTS-1:0]              slot_open,
    input  logic [NUM_SLOTS-1:0][ROW_W-1:0]   slot_rows,
    output logic [NUM_SLOTS-1:0]              open_vec,
    output logic [NUM_SLOTS-1:0]              close_vec,
    output logic                              cmd_err
);

    logic [SLOT_W-1:0] idx;
    logic              cur_open;
    logic              row_eq;
    cmd_op_e           op;

    always_comb begin
        idx      = {cmd_rank, cmd_bank};
        cur_open = slot_open[idx];
        row_eq   = (slot_rows[idx] == cmd_row);
        op       = cmd_op_e'(cmd_op);
    end

    always_comb begin
        open_vec  = '0;
        close_vec = '0;
        cmd_err   = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_ACT: begin
                    if (cur_open) cmd_err = 1'b1;
                    else          open_vec[idx] = 1'b1;
                end
                OP_PRE: close_vec[idx] = 1'b1;
                OP_PREA: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        close_vec[{cmd_rank, BANK_W'(b)}] = 1'b1;
                    end
                end
                OP_RD, OP_WR: begin
                    if (!cur_open || !row_eq) cmd_err = 1'b1;
                end
                OP_NOP, OP_RSV6, OP_RSV7: ;
            endcase
        end
    end

endmodule

// File: rtl/bank_req_classify.sv
module bank_req_classify
    import bank_trk_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    localparam int SLOT_W    = RANK_W + BANK_W,
    localparam int NUM_SLOTS = 1 << SLOT_W
) (
    input  logic [RANK_W-1:0]                req_rank,
    input  logic [BANK_W-1:0]                req_bank,
    input  logic [ROW_W-1:0]                 req_row,
    input  logic [NUM_SLOTS-1:0]             slot_open,
    input  logic [NUM_SLOTS-1:0][ROW_W-1:0]  slot_rows,
    output row_cls_e                         cls
);

    logic [SLOT_W-1:0] idx;

    always_comb begin
        idx = {req_rank, req_bank};
        if (!slot_open[idx])                   cls = CLS_EMPTY;
        else if (slot_rows[idx] == req_row)    cls = CLS_HIT;
        else                                   cls = CLS_CONFLICT;
    end

endmodule

// File: rtl/bank_err_pulse.sv
module bank_err_pulse
    import bank_trk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_in,
    output logic err_out
);

    err_st_e st_q;
    err_st_e st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= EP_QUIET;
        else     st_q <= st_d;
    end

    // T_RAISE / T_DROP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EP_QUIET: if (err_in)  st_d = EP_FLAG;
            EP_FLAG:  if (!err_in) st_d = EP_QUIET;
        endcase
    end

    always_comb begin
        err_out = (st_q == EP_FLAG);
    end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import bank_trk_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic [1:0]        req_class,
    output logic              proto_err
);

    localparam int SLOT_W    = RANK_W + BANK_W;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    logic [NUM_SLOTS-1:0]            slot_open;
    logic [NUM_SLOTS-1:0][ROW_W-1:0] slot_rows;
    logic [NUM_SLOTS-1:0]            open_vec;
    logic [NUM_SLOTS-1:0]            close_vec;
    logic                            cmd_err;
    row_cls_e                        cls;

    bank_cmd_decode #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_rank  (cmd_rank),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .slot_open (slot_open),
        .slot_rows (slot_rows),
        .open_vec  (open_vec),
        .close_vec (close_vec),
        .cmd_err   (cmd_err)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        bank_row_slot #(.ROW_W(ROW_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .open_req  (open_vec[g]),
            .close_req (close_vec[g]),
            .row_in    (cmd_row),
            .is_open   (slot_open[g]),
            .open_row  (slot_rows[g])
        );
    end

    bank_req_classify #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_cls (
        .req_rank  (req_rank),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .slot_open (slot_open),
        .slot_rows (slot_rows),
        .cls       (cls)
    );

    bank_err_pulse u_err (
        .clk     (clk),
        .rst     (rst),
        .err_in  (cmd_err),
        .err_out (proto_err)
    );

    assign req_class = cls;

endmodule

// File: rtl/bank_row_tracker_chk.sv
module bank_row_tracker_chk
    import bank_trk_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    localparam int SLOT_W    = RANK_W + BANK_W,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             cmd_valid,
    input logic [2:0]                       cmd_op,
    input logic [RANK_W-1:0]                cmd_rank,
    input logic [BANK_W-1:0]                cmd_bank,
    input logic [ROW_W-1:0]                 cmd_row,
    input logic [RANK_W-1:0]                req_rank,
    input logic [BANK_W-1:0]                req_bank,
    input logic [ROW_W-1:0]                 req_row,
    input logic [1:0]                       req_class,
    input logic                             proto_err,
    input logic [NUM_SLOTS-1:0]             slot_open,
    input logic [NUM_SLOTS-1:0][ROW_W-1:0]  slot_rows
);

    logic [SLOT_W-1:0]    cidx;
    logic [SLOT_W-1:0]    ridx;
    logic [RANK_W-1:0]    p_rank;
    logic [NUM_BANKS-1:0] prev_rank_open;

    always_comb begin
        cidx = {cmd_rank, cmd_bank};
        ridx = {req_rank, req_bank};
        for (int b = 0; b < NUM_BANKS; b++) begin
            prev_rank_open[b] = slot_open[{p_rank, BANK_W'(b)}];
        end
    end

    always_ff @(posedge clk) begin
        p_rank <= cmd_rank;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_open == '0 && !proto_err));

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(OP_ACT) && !slot_open[cidx])
        |=> (slot_open[$past(cidx)] && slot_rows[$past(cidx)] == $past(cmd_row) && !proto_err));

    assert_hit_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (req_class == 2'(CLS_HIT)) |-> (slot_open[ridx] && slot_rows[ridx] == req_row));

    assert_no_code3_R3: assert property (@(posedge clk) disable iff (rst)
        req_class != 2'b11);

    assert_pre_closes_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(OP_PRE)) |=> (!slot_open[$past(cidx)] && !proto_err));

    assert_prea_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(OP_PREA)) |=> (prev_rank_open == '0 && !proto_err));

    assert_act_busy_err_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(OP_ACT) && slot_open[cidx])
        |=> (proto_err && $stable(slot_open) && $stable(slot_rows)));

    assert_rw_bad_err_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'(OP_RD) || cmd_op == 3'(OP_WR))
         && !(slot_open[cidx] && slot_rows[cidx] == cmd_row))
        |=> (proto_err && $stable(slot_open) && $stable(slot_rows)));

    assert_idle_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid) |=> (!proto_err && $stable(slot_open) && $stable(slot_rows)));

endmodule

bind bank_row_tracker bank_row_tracker_chk #(
    .RANK_W (RANK_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_rank  (cmd_rank),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row),
    .req_rank  (req_rank),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_class (req_class),
    .proto_err (proto_err),
    .slot_open (slot_open),
    .slot_rows (slot_rows)
);

// File: tb/sim_bank_row_tracker.sv
module sim_bank_row_tracker;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_rank;
    logic [2:0]  cmd_bank;
    logic [15:0] cmd_row;
    logic [1:0]  req_rank;
    logic [2:0]  req_bank;
    logic [15:0] req_row;
    logic [1:0]  req_class;
    logic        proto_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [1:0] EMPTY = 2'b00, HIT = 2'b01, CONF = 2'b10;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, PREA = 3'd3,
                           RD = 3'd4, WR = 3'd5;

    // {op, rank, bank, row, expected proto_err, expected class of same address/row}
    localparam int NV = 15;
    localparam logic [26:0] VEC [NV] = '{
        {ACT,  2'd0, 3'd0, 16'h0010, 1'b0, HIT},   // R2
        {RD,   2'd0, 3'd0, 16'h0010, 1'b0, HIT},   // R8 legal read
        {WR,   2'd0, 3'd0, 16'h0011, 1'b1, CONF},  // R8 mismatch, R3 conflict
        {ACT,  2'd0, 3'd0, 16'h0022, 1'b1, CONF},  // R7 busy activate
        {ACT,  2'd0, 3'd1, 16'h0022, 1'b0, HIT},   // R4 other bank
        {RD,   2'd0, 3'd2, 16'h0022, 1'b1, EMPTY}, // R8 idle bank
        {PRE,  2'd0, 3'd0, 16'h0000, 1'b0, EMPTY}, // R5
        {ACT,  2'd3, 3'd7, 16'hFFFF, 1'b0, HIT},   // R2 top slot
        {ACT,  2'd1, 3'd7, 16'hFFFF, 1'b0, HIT},   // R2
        {PREA, 2'd3, 3'd0, 16'h0000, 1'b0, EMPTY}, // R6
        {RD,   2'd3, 3'd7, 16'hFFFF, 1'b1, EMPTY}, // R6 closed r3b7
        {WR,   2'd1, 3'd7, 16'hFFFF, 1'b0, HIT},   // R4 rank1 untouched by R6
        {RD,   2'd0, 3'd1, 16'h0022, 1'b0, HIT},   // R4 bank1 untouched by R5
        {PRE,  2'd0, 3'd3, 16'h0000, 1'b0, EMPTY}, // R5 idle precharge
        {NOP,  2'd1, 3'd7, 16'h1234, 1'b0, CONF}   // R10, R3
    };

    bank_row_tracker u0 (
        .clk, .rst, .cmd_valid, .cmd_op, .cmd_rank, .cmd_bank, .cmd_row,
        .req_rank, .req_bank, .req_row, .req_class, .proto_err
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cmd(input logic v, input logic [2:0] op, input logic [1:0] rk,
                           input logic [2:0] bk, input logic [15:0] row);
        cmd_valid = v; cmd_op = op; cmd_rank = rk; cmd_bank = bk; cmd_row = row;
        req_rank = rk; req_bank = bk; req_row = row;
    endtask

    task automatic look(input logic [1:0] rk, input logic [2:0] bk, input logic [15:0] row);
        req_rank = rk; req_bank = bk; req_row = row;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        set_cmd(1'b0, NOP, 2'd0, 3'd0, 16'h0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        look(2'd0, 3'd0, 16'h0);
        check("R1 lookup after reset", 32'(req_class), 32'(EMPTY));
        check("R1 proto_err after reset", 32'(proto_err), 32'd0);
        look(2'd3, 3'd7, 16'hFFFF);
        check("R1 top slot idle", 32'(req_class), 32'(EMPTY));

        for (int i = 0; i < NV; i++) begin
            set_cmd(1'b1, VEC[i][26:24], VEC[i][23:22], VEC[i][21:19], VEC[i][18:3]);
            @(posedge clk);
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            check($sformatf("R7/R8 err vec%0d", i), 32'(proto_err), 32'(VEC[i][2]));
            check($sformatf("R2-R6 class vec%0d", i), 32'(req_class), 32'(VEC[i][1:0]));
        end

        // R9: lookup in the same cycle as an activate sees the old state
        @(negedge clk);
        set_cmd(1'b1, ACT, 2'd2, 3'd4, 16'h0ABC);
        #1;
        check("R9 pre-update view", 32'(req_class), 32'(EMPTY));
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check("R9 post-update view", 32'(req_class), 32'(HIT));

        // R10: valid low with an activate opcode does nothing
        set_cmd(1'b0, ACT, 2'd2, 3'd5, 16'h0005);
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R10 valid low state", 32'(req_class), 32'(EMPTY));
        check("R10 valid low err", 32'(proto_err), 32'd0);

        // R10: reserved opcode aimed at an open bank does nothing
        set_cmd(1'b1, 3'd6, 2'd2, 3'd4, 16'h0DEF);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        look(2'd2, 3'd4, 16'h0ABC);
        check("R10 reserved op state", 32'(req_class), 32'(HIT));
        check("R10 reserved op err", 32'(proto_err), 32'd0);

        // R7: error is a single-cycle pulse
        set_cmd(1'b1, ACT, 2'd2, 3'd4, 16'h0001);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check("R7 pulse high", 32'(proto_err), 32'd1);
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R7 pulse gone", 32'(proto_err), 32'd0);
        look(2'd2, 3'd4, 16'h0ABC);
        check("R7 row kept", 32'(req_class), 32'(HIT));

        // R1: reset with open banks
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        look(2'd2, 3'd4, 16'h0ABC);
        check("R1 reset closes r2b4", 32'(req_class), 32'(EMPTY));
        look(2'd1, 3'd7, 16'hFFFF);
        check("R1 reset closes r1b7", 32'(req_class), 32'(EMPTY));

        finish_run();
    end

endmodule